// File: doc/BRIEF.md
# Permute Control Vector Generator

This block turns a 128-bit element mask into a 128-bit vector of byte selectors for a permute unit that indexes a 32-byte table, meaning two concatenated 16-byte sources. Each selector byte holds a value from 0x00 to 0x1F. Values below 0x10 pick a byte of the first source, and values from 0x10 up pick a byte of the second source. The mask is read one element at a time. An element is one, two, four or eight bytes wide, and it counts as selected when the top bit of that element is set.

A two-bit mode chooses between expansion and compression, and between numbering from the left (big-endian) and numbering from the right (little-endian). Expansion scatters the packed leading elements of the first source into the selected slots and fills every other slot from the second source. Compression gathers the selected elements into consecutive slots at the numbering origin and zeroes the remaining slots.

Each request is captured in one clock and its result is registered. An undefined mode or size code raises an illegal flag and gives an all-zero vector.

Top module: `pcv_gen`

## Requirements
- R1: A request presented with `in_valid` high produces `out_valid` high on exactly the next clock. `out_valid` is low in every cycle that does not follow a request. A synchronous active-high reset clears `out_valid`, `out_illegal` and `out_pcv`.
- R2: The element width comes from `in_size`: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. An element is selected only when its most significant mask bit is set. Every other mask bit has no effect on the result.
- R3: Mode 0 is big-endian expansion. Elements and the bytes inside them are numbered from the left, starting at 0, and S is the element width in bytes. Let j be the number of selected elements to the left of element k. A selected element k gets bytes S*j+b, where b is its byte number from the left. An unselected element k gets bytes 0x10+S*k+b.
- R4: Mode 1 is big-endian compression. The n-th selected element from the left, counted from 0, lands in result slot n counted from the left. That element is element k, and its bytes S*k+b are written into the slot. All result slots from the number of selected elements upward read zero.
- R5: Mode 2 is little-endian expansion. It follows R3, except that elements and bytes are numbered from the right. The selector values inside one element therefore rise toward its more significant byte.
- R6: Mode 3 is little-endian compression. It follows R4, except that slots, elements and bytes are numbered from the right. Unused slots read zero.
- R7: A mode value from 4 to 31 on `in_mode` makes the next output carry `out_illegal` high and `out_pcv` all zero.
- R8: A size code from 4 to 7 on `in_size` makes the next output carry `out_illegal` high and `out_pcv` all zero.
- R9: While `in_valid` is low, `out_pcv` and `out_illegal` keep their last values, whatever the other inputs do.
- R10: A request with a defined mode and a defined size drives `out_illegal` low on the next output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mask | input | 128 | Element mask; bit 127 is the leftmost bit |
| in_size | input | 3 | Element size code (0 to 3 defined) |
| in_mode | input | 5 | Mode immediate (0 to 3 defined) |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_illegal | output | 1 | Request carried an undefined code |
| out_pcv | output | 128 | Byte selector vector; bits 127:120 are the leftmost byte |

## Verification
The bench builds the block with its default 16-byte vector width. At that width all four element sizes are reachable, from sixteen single-byte elements down to two 8-byte elements. This exposes the extremes of the running count: no element selected, every element selected, and a single element at either end of the scan. Fixed all-ones and all-zeros masks pin known selector vectors in every mode. Pseudo-random masks are then checked against a model written directly from the requirements, and a second copy of each random mask with every non-MSB bit set shows that only the element MSBs matter.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

    typedef enum logic [1:0] {
        MODE_BE_EXPAND   = 2'd0,
        MODE_BE_COMPRESS = 2'd1,
        MODE_LE_EXPAND   = 2'd2,
        MODE_LE_COMPRESS = 2'd3
    } pcv_mode_e;

    localparam int SIZE_CODES = 4;   // 1, 2, 4 and 8 byte elements

    // Mode bit 0 picks compression, mode bit 1 picks right-origin numbering.
    function automatic logic mode_is_compress(input pcv_mode_e m);
        return (m == MODE_BE_COMPRESS) || (m == MODE_LE_COMPRESS);
    endfunction

    function automatic logic mode_is_le(input pcv_mode_e m);
        return (m == MODE_LE_EXPAND) || (m == MODE_LE_COMPRESS);
    endfunction

endpackage

// File: rtl/pcv_elem_tap.sv
// Pulls the MSB of every element out of the mask, ordered in scan order:
// the first bit is the element nearest the numbering origin.
module pcv_elem_tap #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0] mask,
    input  logic                le,
    input  logic [1:0]          size_sh,
    output logic [NBYTES-1:0]   sel
);
    localparam int VEC_W = NBYTES * 8;

    logic [pcv_pkg::SIZE_CODES-1:0][NBYTES-1:0] tap;

    for (genvar sz = 0; sz < pcv_pkg::SIZE_CODES; sz++) begin : g_size
        localparam int EW = 8 << sz;
        localparam int NE = NBYTES >> sz;
        for (genvar e = 0; e < NBYTES; e++) begin : g_elem
            if (e < NE) begin : g_live
                assign tap[sz][e] = le ? mask[e*EW + EW - 1]
                                       : mask[VEC_W - 1 - e*EW];
            end else begin : g_dead
                assign tap[sz][e] = 1'b0;
            end
        end
    end

    assign sel = tap[size_sh];

endmodule

// File: rtl/pcv_prefix_cnt.sv
// Exclusive prefix popcount: cnt[e] = selected elements ahead of e in scan order.
module pcv_prefix_cnt #(
    parameter int NBYTES = 16,
    localparam int CW = $clog2(NBYTES + 1)
) (
    input  logic [NBYTES-1:0]         sel,
    output logic [NBYTES-1:0][CW-1:0] cnt
);
    always_comb begin
        cnt[0] = '0;
        for (int e = 1; e < NBYTES; e++) begin
            cnt[e] = cnt[e-1] + CW'(sel[e-1]);
        end
    end

endmodule

// File: rtl/pcv_byte_map.sv
// Builds the selector bytes in scan order (position 0 at the numbering origin).
module pcv_byte_map #(
    parameter int NBYTES = 16,
    localparam int CW = $clog2(NBYTES + 1)
) (
    input  logic [NBYTES-1:0]         sel,
    input  logic [NBYTES-1:0][CW-1:0] cnt,
    input  logic [1:0]                size_sh,
    input  logic                      compress,
    output logic [NBYTES-1:0][7:0]    scan
);
    always_comb begin
        int sh;
        int e;
        int b;
        int acc;
        sh = int'(size_sh);
        for (int q = 0; q < NBYTES; q++) begin
            e   = q >> sh;
            b   = q & ((1 << sh) - 1);
            acc = 0;
            if (compress) begin
                // slot e holds the selected element whose rank equals e
                for (int k = 0; k < NBYTES; k++) begin
                    if (sel[k] && (int'(cnt[k]) == e)) begin
                        acc = acc | ((k << sh) + b);
                    end
                end
            end else if (sel[e]) begin
                acc = (int'(cnt[e]) << sh) + b;
            end else begin
                acc = NBYTES + q;
            end
            scan[q] = 8'(acc);
        end
    end

endmodule

// File: rtl/pcv_gen.sv
module pcv_gen #(
    parameter int NBYTES = 16,
    localparam int VEC_W = NBYTES * 8,
    localparam int CW = $clog2(NBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_mask,
    input  logic [2:0]       in_size,
    input  logic [4:0]       in_mode,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [VEC_W-1:0] out_pcv
);
    import pcv_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] pcv;
    } out_state_t;

    out_state_t st_d, st_q;

    pcv_mode_e                 mode;
    logic                      legal;
    logic [NBYTES-1:0]         sel;
    logic [NBYTES-1:0][CW-1:0] cnt;
    logic [NBYTES-1:0][7:0]    scan;
    logic [VEC_W-1:0]          placed;

    assign mode  = pcv_mode_e'(in_mode[1:0]);
    assign legal = (in_mode[4:2] == 3'd0) && !in_size[2];

    pcv_elem_tap #(.NBYTES(NBYTES)) i_tap (
        .mask    (in_mask),
        .le      (mode_is_le(mode)),
        .size_sh (in_size[1:0]),
        .sel     (sel)
    );

    pcv_prefix_cnt #(.NBYTES(NBYTES)) i_cnt (
        .sel (sel),
        .cnt (cnt)
    );

    pcv_byte_map #(.NBYTES(NBYTES)) i_map (
        .sel      (sel),
        .cnt      (cnt),
        .size_sh  (in_size[1:0]),
        .compress (mode_is_compress(mode)),
        .scan     (scan)
    );

    // Scan order to physical byte lanes; lane 0 is the leftmost byte.
    for (genvar p = 0; p < NBYTES; p++) begin : g_lane
        assign placed[VEC_W-1-8*p -: 8] = mode_is_le(mode) ? scan[NBYTES-1-p]
                                                           : scan[p];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.illegal = !legal;
            st_d.pcv     = legal ? placed : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_pcv     = st_q.pcv;

endmodule

// File: rtl/pcv_gen_chk.sv
module pcv_gen_chk #(
    parameter int NBYTES = 16,
    localparam int VEC_W = NBYTES * 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [VEC_W-1:0] in_mask,
    input logic [2:0]       in_size,
    input logic [4:0]       in_mode,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [VEC_W-1:0] out_pcv
);
    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                        // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                      // R1
    AST_BAD_MODE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode > 5'd3) |=> (out_illegal && out_pcv == '0)); // R7
    AST_BAD_SIZE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size > 3'd3) |=> (out_illegal && out_pcv == '0)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_pcv) && $stable(out_illegal)));      // R9
    AST_GOOD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode <= 5'd3 && in_size <= 3'd3) |=> !out_illegal); // R10
    AST_EMPTY_GATHER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[4:1] == 4'd0 && in_mode[0] && in_mask == '0
         && in_size <= 3'd3) |=> (out_pcv == '0));                      // R4
    AST_EMPTY_GATHER_LE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 5'd3 && in_mask == '0 && in_size <= 3'd3)
        |=> (out_pcv == '0));                                           // R6
endmodule

bind pcv_gen pcv_gen_chk #(.NBYTES(NBYTES)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_mask     (in_mask),
    .in_size     (in_size),
    .in_mode     (in_mode),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_pcv     (out_pcv)
);

// File: tb/test_pcv_gen.sv
`timescale 1ns/1ps
module test_pcv_gen;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_mask = '0;
    logic [2:0]   in_size = '0;
    logic [4:0]   in_mode = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_pcv;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    pcv_gen i_pcv_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mask(in_mask),
        .in_size(in_size), .in_mode(in_mode), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_pcv(out_pcv)
    );

    // Model written from the requirements: scan elements from the origin.
    function automatic logic [127:0] ref_pcv(input logic [127:0] m,
                                             input int sz, input int md);
        logic [127:0] r;
        int s, n, w, j, pe, q, p, v;
        bit le, cmp, hit;
        s = 1 << sz; n = 16 / s; w = 8 * s;
        le = md[1]; cmp = md[0];
        r = '0; j = 0;
        for (int e = 0; e < n; e++) begin
            pe  = le ? (n - 1 - e) : e;
            hit = m[127 - pe*w];
            for (int b = 0; b < s; b++) begin
                if (cmp) begin
                    q = j*s + b; v = s*e + b;
                end else begin
                    q = e*s + b; v = hit ? (s*j + b) : (16 + s*e + b);
                end
                p = le ? (15 - q) : q;
                if (!cmp || hit) r[127 - 8*p -: 8] = 8'(v);
            end
            if (hit) j++;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%032h exp=%032h", tag, act, exp);
        end
    endtask

    task automatic request(input logic [127:0] m, input int sz, input int md);
        @(negedge clk);
        in_valid = 1'b1; in_mask = m; in_size = 3'(sz); in_mode = 5'(md);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset valid", {127'd0, out_valid}, 128'd0);
        check("R1 reset illegal", {127'd0, out_illegal}, 128'd0);
        check("R1 reset pcv", out_pcv, 128'd0);
    endtask

    task automatic t_latency();
        request({128{1'b1}}, 0, 0);
        check("R1 valid after request", {127'd0, out_valid}, 128'd1);
        @(negedge clk);
        check("R1 valid drops", {127'd0, out_valid}, 128'd0);
    endtask

    task automatic t_fixed();
        request({128{1'b1}}, 0, 0);
        check("R3 byte all ones", out_pcv, 128'h000102030405060708090A0B0C0D0E0F);
        request('0, 0, 0);
        check("R3 byte all zero", out_pcv, 128'h101112131415161718191A1B1C1D1E1F);
        request({128{1'b1}}, 0, 3);
        check("R6 byte all ones", out_pcv, 128'h0F0E0D0C0B0A09080706050403020100);
        request('0, 2, 1);
        check("R4 empty gather", out_pcv, 128'd0);
        request({1'b1, 127'd0}, 3, 1);
        check("R4 dword left only", out_pcv, 128'h0001020304050607_0000000000000000);
        request({64'd0, 1'b1, 63'd0}, 2, 2);
        check("R5 word lsb-side", out_pcv, ref_pcv({64'd0, 1'b1, 63'd0}, 2, 2));
    endtask

    task automatic t_modes();
        logic [127:0] m;
        for (int it = 0; it < 24; it++) begin
            m = {$urandom, $urandom, $urandom, $urandom};
            for (int sz = 0; sz < 4; sz++) begin
                request(m, sz, 0); check("R3 expand be", out_pcv, ref_pcv(m, sz, 0));
                request(m, sz, 1); check("R4 compress be", out_pcv, ref_pcv(m, sz, 1));
                request(m, sz, 2); check("R5 expand le", out_pcv, ref_pcv(m, sz, 2));
                request(m, sz, 3); check("R6 compress le", out_pcv, ref_pcv(m, sz, 3));
                check("R10 flag low", {127'd0, out_illegal}, 128'd0);
            end
        end
    endtask

    task automatic t_msb_only();
        logic [127:0] m, noise, r0;
        for (int sz = 0; sz < 4; sz++) begin
            for (int md = 0; md < 4; md++) begin
                m = {$urandom, $urandom, $urandom, $urandom};
                noise = '0;
                for (int e = 0; e < (16 >> sz); e++)
                    noise[127 - e*(8 << sz)] = 1'b1;
                request(m & noise, sz, md);
                r0 = out_pcv;
                request(m | ~noise, sz, md);
                check("R2 non-msb ignored", out_pcv, r0);
            end
        end
    endtask

    task automatic t_illegal();
        request({128{1'b1}}, 0, 4);
        check("R7 mode 4 flag", {127'd0, out_illegal}, 128'd1);
        check("R7 mode 4 zero", out_pcv, 128'd0);
        request({128{1'b1}}, 1, 31);
        check("R7 mode 31 zero", {out_illegal, out_pcv[126:0]}, {1'b1, 127'd0});
        request({128{1'b1}}, 5, 0);
        check("R8 size 5 flag", {127'd0, out_illegal}, 128'd1);
        check("R8 size 5 zero", out_pcv, 128'd0);
        request({128{1'b1}}, 1, 2);
        check("R10 flag cleared", {127'd0, out_illegal}, 128'd0);
    endtask

    task automatic t_hold();
        logic [127:0] keep;
        request(128'h8000_0000_0000_0000_8000_0000_0000_0000, 3, 2);
        keep = out_pcv;
        @(negedge clk);
        in_mask = {128{1'b1}}; in_mode = 5'd9; in_size = 3'd6;
        repeat (3) @(negedge clk);
        check("R9 pcv held", out_pcv, keep);
        check("R9 illegal held", {127'd0, out_illegal}, 128'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latency();
        t_fixed();
        t_modes();
        t_msb_only();
        t_illegal();
        t_hold();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule